// File: doc/BRIEF.md
# Multi-Address SMBus Target Decoder

This block sits behind an SMBus bit shifter in a hardware-monitor device and decides what each completed bus transaction means. The device answers at one programmable main address and at up to two further addresses that behave like stand-alone temperature sensors. The shifter hands over the 7-bit target address, the transaction kind, the command byte and up to 16 bits of write data. The decoder picks the target that was hit and issues one or two register-file accesses (bank and register index). It then returns a one-cycle reply carrying the hit flag, the target code and any read data.

The main address and the sensor-address control byte live inside the block and are written like any other bank-0 register, so software moves the device on the bus with ordinary register writes. On a sensor address, word transfers use a pointer-style decode of the low two command bits and land on a register pair in the sensor's own bank, with the first register of the pair in the low byte of read data. Byte transfers on any hit address go to bank 0.

A small state machine sequences the work: `ST_IDLE` (ready, accepts a transaction), `ST_FIRST` (first register access), `ST_SECOND` (second access of a sensor pair) and `ST_REPLY` (reply pulse). The transitions are:
- `ST_IDLE` to `ST_REPLY` on a miss or a pointer load.
- `ST_IDLE` to `ST_FIRST` on any other hit.
- `ST_FIRST` to `ST_SECOND` for a sensor pair, otherwise to `ST_REPLY`.
- `ST_SECOND` to `ST_REPLY`.
- `ST_REPLY` to `ST_IDLE`.

Top module: `smbmon_decoder`

## Requirements
- R1: After reset the main address is 0x2D and the control byte is 0x01, so sensor A answers at 0x49 and sensor B at 0x48. A byte read on the main address with command 0x48 returns 0x2D, and with command 0x4A returns 0x01. `txn_ready` is high and `resp_valid` and `acc_valid` are low.
- R2: An address hits only when it is nonzero and equals an enabled target address. The priority is main, then sensor A, then sensor B. `resp_target` is 0 for a miss, 1 for main, 2 for sensor A and 3 for sensor B. A miss makes no register access and replies with `resp_hit` low.
- R3: The sensor A address is 0x48 plus control bits 2:0, and control bit 3 disables it. The sensor B address is 0x48 plus control bits 6:4, and control bit 7 disables it.
- R4: A write to bank-0 register 0x48 sets the main address from its low 7 bits, and a write to register 0x4A sets the control byte. Each new value applies from the next transaction, and reading either register back returns the stored byte.
- R5: Kind code 0 (send byte) on any hit address loads `txn_cmd` into the register pointer with no access. Kind code 1 (receive byte) reads bank 0 at the pointer and returns {8'h00, byte}.
- R6: Kind code 2 (byte write) writes the low data byte to bank 0 at `txn_cmd`. Kind code 3 (byte read) reads bank 0 at `txn_cmd` and returns {8'h00, byte}. Both hold on any hit address.
- R7: A word transfer (kind 4 write, kind 5 read) on a sensor address uses the sensor's bank (sensor A bank 1, sensor B bank 2). Command bits 1:0 select the registers: 0 gives the pair 0x50/0x51, 1 gives the single register 0x52, 2 gives the pair 0x53/0x54 and 3 gives the pair 0x55/0x56. The two accesses of a pair come in consecutive cycles, first register first.
- R8: A sensor word read returns the first register of the pair in bits 7:0 and the second in bits 15:8. A read of the single register 0x52 returns its byte in both halves.
- R9: A sensor word write puts data bits 15:8 into the first register of the pair and bits 7:0 into the second. A write to register 0x52 stores bits 7:0 only. A word write on the main address stores bits 7:0 at bank 0 `txn_cmd`. A word read there returns that byte in both halves.
- R10: `txn_ready` is high only in `ST_IDLE` and never while an access is issued. `resp_valid` is a single-cycle pulse, after which the block is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Decoded transaction present |
| txn_ready | output | 1 | Block idle, transaction accepted this cycle |
| txn_addr | input | 7 | Target address from the shifter |
| txn_kind | input | 3 | Transaction kind code (0..5) |
| txn_cmd | input | 8 | Command byte, or pointer value for send byte |
| txn_wdata | input | 16 | Write data, high and low byte |
| acc_valid | output | 1 | Register access this cycle |
| acc_we | output | 1 | Access is a write |
| acc_bank | output | 2 | Register bank |
| acc_reg | output | 8 | Register index |
| acc_wdata | output | 8 | Byte to write |
| acc_rdata | input | 8 | Byte read from the register file, same cycle |
| resp_valid | output | 1 | Reply pulse |
| resp_hit | output | 1 | Address matched a target |
| resp_target | output | 2 | Target code of the hit |
| resp_data | output | 16 | Read data of the transaction |

## Verification
A stale or wrong address register shows on the very next transaction, as a `resp_hit` or `resp_target` that differs from the programmed control byte. A corrupted pointer or latched command shows as a wrong `acc_reg` in the first access cycle after acceptance. A sequencing fault in the state machine shows within two cycles of acceptance. It appears as a missing or out-of-order second pair access, swapped halves in `resp_data`, or a reply pulse that lasts longer than one cycle or leaves `txn_ready` low.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;

    typedef enum logic [2:0] {
        K_SEND  = 3'd0,
        K_RECV  = 3'd1,
        K_WBYTE = 3'd2,
        K_RBYTE = 3'd3,
        K_WWORD = 3'd4,
        K_RWORD = 3'd5
    } txn_kind_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_MAIN = 2'd1,
        TGT_SNSA = 2'd2,
        TGT_SNSB = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_REPLY  = 2'd3
    } state_e;

    // offset of the first register selected by a sensor pointer code
    function automatic logic [7:0] pair_offset(input logic [1:0] sel);
        logic [7:0] off;
        unique case (sel)
            2'd0: off = 8'd0;
            2'd1: off = 8'd2;
            2'd2: off = 8'd3;
            2'd3: off = 8'd5;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/smbmon_addr_regs.sv
module smbmon_addr_regs #(
    parameter int             AW        = 7,
    parameter int             DW        = 8,
    parameter int             NSENS     = 2,
    parameter logic [DW-1:0]  MAIN_INIT = 8'h2D,
    parameter logic [DW-1:0]  CTRL_INIT = 8'h01,
    parameter logic [AW-1:0]  SENS_BASE = 7'h48,
    parameter logic [DW-1:0]  MAIN_IDX  = 8'h48,
    parameter logic [DW-1:0]  CTRL_IDX  = 8'h4A
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [DW-1:0]             wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic [DW-1:0]             main_q,
    output logic [DW-1:0]             ctrl_q,
    output logic [NSENS:0][AW-1:0]    tgt_addr
);
    localparam int FIELD_W = 4;
    localparam int OFS_W   = FIELD_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= MAIN_INIT;
            ctrl_q <= CTRL_INIT;
        end else if (wr_en) begin
            if (wr_idx == MAIN_IDX) main_q <= wr_data;
            if (wr_idx == CTRL_IDX) ctrl_q <= wr_data;
        end
    end

    assign tgt_addr[0] = main_q[AW-1:0];

    for (genvar k = 0; k < NSENS; k++) begin : g_sens
        logic              dis;
        logic [OFS_W-1:0]  ofs;
        assign dis = ctrl_q[k*FIELD_W + OFS_W];
        assign ofs = ctrl_q[k*FIELD_W +: OFS_W];
        assign tgt_addr[k+1] = dis ? '0 : SENS_BASE + AW'(ofs);
    end

endmodule

// File: rtl/smbmon_addr_match.sv
module smbmon_addr_match #(
    parameter int AW = 7,
    parameter int N  = 3,
    localparam int IW = $clog2(N + 1)
) (
    input  logic [N-1:0][AW-1:0] tgt_addr,
    input  logic [AW-1:0]        probe,
    output logic [IW-1:0]        sel
);
    logic [N-1:0] hit_vec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = (tgt_addr[i] != '0) && (tgt_addr[i] == probe);
    end

    // lowest index wins
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IW'(i + 1);
        end
    end

endmodule

// File: rtl/smbmon_decoder.sv
module smbmon_decoder
    import smbmon_pkg::*;
#(
    parameter int            AW            = 7,
    parameter int            DW            = 8,
    parameter bit            SMBUS_PRESENT = 1'b1,
    parameter logic [6:0]    MAIN_DEFAULT  = 7'h2D,
    parameter logic [6:0]    SENS_BASE     = 7'h48,
    parameter logic [7:0]    MAIN_IDX      = 8'h48,
    parameter logic [7:0]    CTRL_IDX      = 8'h4A,
    parameter logic [7:0]    PAIR_BASE     = 8'h50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txn_valid,
    output logic            txn_ready,
    input  logic [AW-1:0]   txn_addr,
    input  logic [2:0]      txn_kind,
    input  logic [DW-1:0]   txn_cmd,
    input  logic [2*DW-1:0] txn_wdata,
    output logic            acc_valid,
    output logic            acc_we,
    output logic [1:0]      acc_bank,
    output logic [DW-1:0]   acc_reg,
    output logic [DW-1:0]   acc_wdata,
    input  logic [DW-1:0]   acc_rdata,
    output logic            resp_valid,
    output logic            resp_hit,
    output logic [1:0]      resp_target,
    output logic [2*DW-1:0] resp_data
);
    localparam int          NSENS     = 2;
    localparam int          NTGT      = NSENS + 1;
    localparam logic [DW-1:0] MAIN_INIT = SMBUS_PRESENT ? DW'(MAIN_DEFAULT) : '0;
    localparam logic [DW-1:0] CTRL_INIT = SMBUS_PRESENT ? 8'h01 : 8'h88;
    localparam logic [1:0]  SNSA_BANK = 2'd1;
    localparam logic [1:0]  SNSB_BANK = 2'd2;

    state_e                 state_q;
    txn_kind_e              kind_q;
    target_e                tgt_q;
    logic [DW-1:0]          cmd_q;
    logic [2*DW-1:0]        wdata_q;
    logic [DW-1:0]          ptr_q;
    logic [DW-1:0]          lo_q;
    logic [2*DW-1:0]        data_q;

    logic [DW-1:0]          main_q;
    logic [DW-1:0]          ctrl_q;
    logic [NTGT-1:0][AW-1:0] tgt_addr;
    logic [1:0]             match_sel;
    logic                   regs_wr;
    logic [DW-1:0]          rd_byte;

    logic                   on_sensor;
    logic                   word_kind;
    logic                   is_pair;
    logic                   is_read;
    logic [DW-1:0]          sens_first;
    logic [1:0]             sens_bank;

    smbmon_addr_regs #(
        .AW        (AW),
        .DW        (DW),
        .NSENS     (NSENS),
        .MAIN_INIT (MAIN_INIT),
        .CTRL_INIT (CTRL_INIT),
        .SENS_BASE (SENS_BASE),
        .MAIN_IDX  (MAIN_IDX),
        .CTRL_IDX  (CTRL_IDX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (regs_wr),
        .wr_idx   (acc_reg),
        .wr_data  (acc_wdata),
        .main_q   (main_q),
        .ctrl_q   (ctrl_q),
        .tgt_addr (tgt_addr)
    );

    smbmon_addr_match #(
        .AW (AW),
        .N  (NTGT)
    ) u_match (
        .tgt_addr (tgt_addr),
        .probe    (txn_addr),
        .sel      (match_sel)
    );

    // transaction classification from latched fields
    assign on_sensor  = (tgt_q == TGT_SNSA) || (tgt_q == TGT_SNSB);
    assign word_kind  = (kind_q == K_WWORD) || (kind_q == K_RWORD);
    assign is_pair    = on_sensor && word_kind && (cmd_q[1:0] != 2'd1);
    assign is_read    = (kind_q == K_RECV) || (kind_q == K_RBYTE) || (kind_q == K_RWORD);
    assign sens_first = PAIR_BASE + pair_offset(cmd_q[1:0]);
    assign sens_bank  = (tgt_q == TGT_SNSA) ? SNSA_BANK : SNSB_BANK;

    // address registers answer their own reads
    always_comb begin
        rd_byte = acc_rdata;
        if (acc_bank == 2'd0 && acc_reg == MAIN_IDX) rd_byte = main_q;
        else if (acc_bank == 2'd0 && acc_reg == CTRL_IDX) rd_byte = ctrl_q;
    end

    assign regs_wr = acc_valid && acc_we && (acc_bank == 2'd0);

    // state register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_SEND;
            tgt_q   <= TGT_NONE;
            cmd_q   <= '0;
            wdata_q <= '0;
            ptr_q   <= '0;
            lo_q    <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (txn_valid) begin
                        kind_q  <= txn_kind_e'(txn_kind);
                        tgt_q   <= target_e'(match_sel);
                        cmd_q   <= txn_cmd;
                        wdata_q <= txn_wdata;
                        data_q  <= '0;
                        if (match_sel == 2'd0) begin
                            state_q <= ST_REPLY;
                        end else begin
                            unique case (txn_kind)
                                K_SEND: begin
                                    ptr_q   <= txn_cmd;
                                    state_q <= ST_REPLY;
                                end
                                K_RECV, K_WBYTE, K_RBYTE, K_WWORD, K_RWORD:
                                    state_q <= ST_FIRST;
                                default:
                                    state_q <= ST_REPLY;
                            endcase
                        end
                    end
                end
                ST_FIRST: begin
                    lo_q <= rd_byte;
                    if (is_pair) begin
                        state_q <= ST_SECOND;
                    end else begin
                        if (is_read) begin
                            data_q <= (kind_q == K_RWORD) ? {rd_byte, rd_byte}
                                                          : {{DW{1'b0}}, rd_byte};
                        end
                        state_q <= ST_REPLY;
                    end
                end
                ST_SECOND: begin
                    if (is_read) data_q <= {rd_byte, lo_q};
                    state_q <= ST_REPLY;
                end
                ST_REPLY: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // outputs per state
    always_comb begin
        txn_ready   = 1'b0;
        acc_valid   = 1'b0;
        acc_we      = 1'b0;
        acc_bank    = 2'd0;
        acc_reg     = '0;
        acc_wdata   = '0;
        resp_valid  = 1'b0;
        resp_hit    = (tgt_q != TGT_NONE);
        resp_target = tgt_q;
        resp_data   = data_q;
        unique case (state_q)
            ST_IDLE: begin
                txn_ready = 1'b1;
            end
            ST_FIRST: begin
                acc_valid = 1'b1;
                acc_we    = !is_read;
                if (on_sensor && word_kind) begin
                    acc_bank  = sens_bank;
                    acc_reg   = sens_first;
                    acc_wdata = is_pair ? wdata_q[2*DW-1:DW] : wdata_q[DW-1:0];
                end else if (kind_q == K_RECV) begin
                    acc_reg   = ptr_q;
                end else begin
                    acc_reg   = cmd_q;
                    acc_wdata = wdata_q[DW-1:0];
                end
            end
            ST_SECOND: begin
                acc_valid = 1'b1;
                acc_we    = !is_read;
                acc_bank  = sens_bank;
                acc_reg   = sens_first + 8'd1;
                acc_wdata = wdata_q[DW-1:0];
            end
            ST_REPLY: begin
                resp_valid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/smbmon_decoder_chk.sv
module smbmon_decoder_chk #(
    parameter logic [7:0] PAIR_BASE = 8'h50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       txn_valid,
    input logic       txn_ready,
    input logic [6:0] txn_addr,
    input logic       acc_valid,
    input logic       acc_we,
    input logic [1:0] acc_bank,
    input logic [7:0] acc_reg,
    input logic       resp_valid
);
    logic first_of_pair;
    assign first_of_pair = (acc_reg == PAIR_BASE) || (acc_reg == PAIR_BASE + 8'd3)
                        || (acc_reg == PAIR_BASE + 8'd5);

    // R10: reply lasts one cycle and the block is ready afterwards
    p_reply_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && txn_ready));

    // R10: never ready while a register access is issued
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !txn_ready);

    // R2: address zero never hits
    p_zero_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready && txn_addr == 7'd0) |=> (!acc_valid && resp_valid));

    // R7: a pair's second access follows at once in the same bank
    p_pair_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_bank != 2'd0 && first_of_pair) |=>
        (acc_valid && acc_bank == $past(acc_bank) && acc_reg == $past(acc_reg) + 8'd1
         && acc_we == $past(acc_we)));

    // R7: sensor banks only reach the sensor register window
    p_sensor_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_bank != 2'd0) |->
        (acc_reg >= PAIR_BASE && acc_reg <= PAIR_BASE + 8'd6));

    // R7: bank 3 is never addressed
    p_bank_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_bank != 2'd3));

endmodule

bind smbmon_decoder smbmon_decoder_chk #(.PAIR_BASE(PAIR_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_valid  (txn_valid),
    .txn_ready  (txn_ready),
    .txn_addr   (txn_addr),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .acc_bank   (acc_bank),
    .acc_reg    (acc_reg),
    .resp_valid (resp_valid)
);

// File: tb/smbmon_decoder_tb.sv
module smbmon_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_valid = 1'b0;
    logic        txn_ready;
    logic [6:0]  txn_addr = '0;
    logic [2:0]  txn_kind = '0;
    logic [7:0]  txn_cmd = '0;
    logic [15:0] txn_wdata = '0;
    logic        acc_valid, acc_we;
    logic [1:0]  acc_bank;
    logic [7:0]  acc_reg, acc_wdata, acc_rdata;
    logic        resp_valid, resp_hit;
    logic [1:0]  resp_target;
    logic [15:0] resp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] mem [0:3][0:255];
    int         n_acc = 0;
    int         busy_viol = 0;
    logic [1:0] lg_bank [0:3];
    logic [7:0] lg_reg  [0:3];

    logic        r_hit;
    logic [1:0]  r_tgt;
    logic [15:0] r_data;
    logic        post_ready, post_resp;

    smbmon_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_kind(txn_kind), .txn_cmd(txn_cmd), .txn_wdata(txn_wdata),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_bank(acc_bank),
        .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_target(resp_target),
        .resp_data(resp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign acc_rdata = mem[acc_bank][acc_reg];

    // register-file model and access log, away from the active edge
    always @(negedge clk) begin
        if (acc_valid) begin
            if (n_acc < 4) begin
                lg_bank[n_acc] = acc_bank;
                lg_reg[n_acc]  = acc_reg;
            end
            n_acc = n_acc + 1;
            if (acc_we) mem[acc_bank][acc_reg] = acc_wdata;
            if (txn_ready) busy_viol = busy_viol + 1;
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input logic [6:0] a, input logic [2:0] k,
                           input logic [7:0] c, input logic [15:0] w);
        bit got;
        @(negedge clk);
        n_acc = 0;
        txn_addr = a; txn_kind = k; txn_cmd = c; txn_wdata = w;
        txn_valid = 1'b1;
        @(negedge clk);
        txn_valid = 1'b0;
        got = 1'b0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (resp_valid) begin
                got = 1'b1;
                r_hit = resp_hit; r_tgt = resp_target; r_data = resp_data;
            end else begin
                @(negedge clk);
            end
        end
        check(got, "R10 reply seen", 32'(got), 32'd1);
        @(negedge clk);
        post_ready = txn_ready;
        post_resp  = resp_valid;
    endtask

    // R1: reset values
    task automatic t_reset();
        check(txn_ready == 1'b1, "R1 ready after reset", 32'(txn_ready), 32'd1);
        check(!resp_valid && !acc_valid, "R1 idle outputs",
              32'({resp_valid, acc_valid}), 32'd0);
        run_txn(7'h2D, 3'd3, 8'h48, 16'h0);
        check(r_hit && r_tgt == 2'd1, "R1 main hit", 32'({r_hit, r_tgt}), 32'h5);
        check(r_data == 16'h002D, "R1 main addr reg", 32'(r_data), 32'h2D);
        run_txn(7'h2D, 3'd3, 8'h4A, 16'h0);
        check(r_data == 16'h0001, "R1 ctrl reg", 32'(r_data), 32'h1);
        run_txn(7'h49, 3'd3, 8'h00, 16'h0);
        check(r_tgt == 2'd2, "R1 sensor A at 0x49", 32'(r_tgt), 32'd2);
        run_txn(7'h48, 3'd3, 8'h00, 16'h0);
        check(r_tgt == 2'd3, "R1 sensor B at 0x48", 32'(r_tgt), 32'd3);
    endtask

    // R2: misses
    task automatic t_miss();
        run_txn(7'h2C, 3'd2, 8'h10, 16'h00AA);
        check(!r_hit && r_tgt == 2'd0, "R2 miss flag", 32'({r_hit, r_tgt}), 32'd0);
        check(n_acc == 0, "R2 miss no access", 32'(n_acc), 32'd0);
        check(mem[0][8'h10] == 8'h00, "R2 miss no write", 32'(mem[0][8'h10]), 32'd0);
        run_txn(7'h00, 3'd3, 8'h10, 16'h0);
        check(!r_hit && n_acc == 0, "R2 zero address", 32'({r_hit, 4'(n_acc)}), 32'd0);
    endtask

    // R6: byte transfers with command
    task automatic t_byte();
        run_txn(7'h2D, 3'd2, 8'h30, 16'h77A5);
        check(mem[0][8'h30] == 8'hA5, "R6 byte write", 32'(mem[0][8'h30]), 32'hA5);
        check(n_acc == 1, "R6 one access", 32'(n_acc), 32'd1);
        run_txn(7'h2D, 3'd3, 8'h30, 16'h0);
        check(r_data == 16'h00A5, "R6 byte read", 32'(r_data), 32'hA5);
        run_txn(7'h49, 3'd3, 8'h30, 16'h0);
        check(r_data == 16'h00A5 && r_tgt == 2'd2 && lg_bank[0] == 2'd0,
              "R6 byte read on sensor uses bank 0", 32'(r_data), 32'hA5);
    endtask

    // R5: pointer load and receive
    task automatic t_pointer();
        mem[0][8'h3C] = 8'h5E;
        run_txn(7'h48, 3'd0, 8'h3C, 16'h0);
        check(r_hit && n_acc == 0, "R5 send byte no access",
              32'({r_hit, 4'(n_acc)}), 32'h10);
        run_txn(7'h2D, 3'd1, 8'h00, 16'h0);
        check(lg_reg[0] == 8'h3C && lg_bank[0] == 2'd0, "R5 receive at pointer",
              32'(lg_reg[0]), 32'h3C);
        check(r_data == 16'h005E, "R5 receive data", 32'(r_data), 32'h5E);
    endtask

    // R7/R8: sensor word reads
    task automatic t_sensor_read();
        mem[1][8'h50] = 8'h11; mem[1][8'h51] = 8'h22;
        mem[2][8'h52] = 8'h5C;
        mem[2][8'h53] = 8'h33; mem[2][8'h54] = 8'h44;
        mem[1][8'h55] = 8'h66; mem[1][8'h56] = 8'h77;
        run_txn(7'h49, 3'd5, 8'h00, 16'h0);
        check(r_data == 16'h2211, "R8 temp pair order", 32'(r_data), 32'h2211);
        check(n_acc == 2 && lg_bank[0] == 2'd1 && lg_reg[0] == 8'h50 && lg_reg[1] == 8'h51,
              "R7 pair 0x50 bank 1", 32'(lg_reg[0]), 32'h50);
        run_txn(7'h49, 3'd5, 8'h04, 16'h0);
        check(r_data == 16'h2211, "R7 only low cmd bits", 32'(r_data), 32'h2211);
        run_txn(7'h48, 3'd5, 8'h01, 16'h0);
        check(r_data == 16'h5C5C && n_acc == 1, "R8 config both halves",
              32'(r_data), 32'h5C5C);
        run_txn(7'h48, 3'd5, 8'h02, 16'h0);
        check(r_data == 16'h4433 && lg_bank[0] == 2'd2, "R7 hyst pair bank 2",
              32'(r_data), 32'h4433);
        run_txn(7'h49, 3'd5, 8'h03, 16'h0);
        check(r_data == 16'h7766, "R8 overtemp pair", 32'(r_data), 32'h7766);
    endtask

    // R9: word writes
    task automatic t_word_write();
        run_txn(7'h48, 3'd4, 8'h03, 16'hBEEF);
        check(mem[2][8'h55] == 8'hBE && mem[2][8'h56] == 8'hEF, "R9 pair write order",
              32'({mem[2][8'h55], mem[2][8'h56]}), 32'hBEEF);
        check(n_acc == 2, "R9 pair two accesses", 32'(n_acc), 32'd2);
        mem[1][8'h53] = 8'h00;
        run_txn(7'h49, 3'd4, 8'h01, 16'h1234);
        check(mem[1][8'h52] == 8'h34 && n_acc == 1 && mem[1][8'h53] == 8'h00,
              "R9 config low byte only", 32'(mem[1][8'h52]), 32'h34);
        run_txn(7'h2D, 3'd4, 8'h31, 16'h7788);
        check(mem[0][8'h31] == 8'h88 && mem[0][8'h32] == 8'h00 && n_acc == 1,
              "R9 main word write low byte", 32'(mem[0][8'h31]), 32'h88);
        run_txn(7'h2D, 3'd5, 8'h31, 16'h0);
        check(r_data == 16'h8888, "R9 main word read", 32'(r_data), 32'h8888);
    endtask

    // R10: handshake
    task automatic t_timing();
        busy_viol = 0;
        run_txn(7'h48, 3'd5, 8'h02, 16'h0);
        check(busy_viol == 0, "R10 not ready while busy", 32'(busy_viol), 32'd0);
        check(post_ready && !post_resp, "R10 single reply pulse",
              32'({post_ready, post_resp}), 32'h2);
    endtask

    // R2/R3/R4: reprogramming addresses
    task automatic t_addr_change();
        run_txn(7'h2D, 3'd2, 8'h4A, 16'h002B);
        run_txn(7'h2D, 3'd3, 8'h4A, 16'h0);
        check(r_data == 16'h002B, "R4 ctrl readback", 32'(r_data), 32'h2B);
        run_txn(7'h49, 3'd3, 8'h00, 16'h0);
        check(!r_hit, "R3 sensor A disabled", 32'(r_hit), 32'd0);
        run_txn(7'h4A, 3'd3, 8'h00, 16'h0);
        check(r_hit && r_tgt == 2'd3, "R3 sensor B offset 2", 32'(r_tgt), 32'd3);
        run_txn(7'h2D, 3'd2, 8'h4A, 16'h0085);
        run_txn(7'h4D, 3'd3, 8'h00, 16'h0);
        check(r_tgt == 2'd2, "R3 sensor A offset 5", 32'(r_tgt), 32'd2);
        run_txn(7'h4A, 3'd3, 8'h00, 16'h0);
        check(!r_hit, "R3 sensor B disabled", 32'(r_hit), 32'd0);
        run_txn(7'h2D, 3'd2, 8'h48, 16'h004D);
        run_txn(7'h4D, 3'd3, 8'h00, 16'h0);
        check(r_tgt == 2'd1, "R2 main has priority", 32'(r_tgt), 32'd1);
        run_txn(7'h2D, 3'd3, 8'h00, 16'h0);
        check(!r_hit, "R4 old main address dropped", 32'(r_hit), 32'd0);
        run_txn(7'h4D, 3'd2, 8'h48, 16'h0000);
        run_txn(7'h4D, 3'd3, 8'h00, 16'h0);
        check(r_tgt == 2'd2, "R2 zero main cannot hit", 32'(r_tgt), 32'd2);
        run_txn(7'h00, 3'd3, 8'h00, 16'h0);
        check(!r_hit, "R2 zero address with zero main", 32'(r_hit), 32'd0);
    endtask

    initial begin
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 256; r++)
                mem[b][r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss();
        t_byte();
        t_pointer();
        t_sensor_read();
        t_word_write();
        t_timing();
        t_addr_change();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule